// File: doc/BRIEF.md
# Four-Level Bitonic Compare-Swap Cascade

This block sorts a stream of unsigned words held in an external buffer, four bitonic network steps per pass. Words are fed one per cycle in position order, and the sorted words come back in the same position order. Between the input and the output the stream crosses four compare-swap levels. Each level is a delay line with a two-way switch. That switch pairs every word with the partner a fixed distance away. It writes the lower result to the lower position, then holds the upper result in the delay line until its turn comes. A full sort of `SEQ_LEN = 2^LOG_LEN` words needs `LOG_LEN*(LOG_LEN+1)/2` network steps. The buffer is therefore read and written once per four steps instead of once per step.

The caller sets the network position of the first level: a stage number `s` (merge block size `2^s`, from 1 to `LOG_LEN`) and a step number `t` (pairing distance `2^t`, with `t < s`). The following levels move on through the network by themselves. A level placed past the last stage forwards words unchanged. The stage and step inputs must stay constant from the first word of a pass until its last result has left.

Top module: `bitonic_cascade`

## Requirements
- R1: During reset and in the first cycle after reset, `out_valid` is low.
- R2: A level at step `t` pairs position `p` with position `p + 2^t` for every `p` whose bit `t` is 0. When the pair is ascending, the smaller word goes to position `p` and the larger to `p + 2^t`. Equal words pass through unchanged.
- R3: A pair is descending (larger word to position `p`) when the stage `s` is below `LOG_LEN` and bit `s` of `p` is 1. Otherwise it is ascending, and that includes every pair of the final stage.
- R4: Level k+1 runs the step after level k. If level k is at `(s, t)` with `t > 0`, level k+1 runs `(s, t-1)`. If `t = 0`, level k+1 runs `(s+1, s)`.
- R5: A level whose position lies beyond stage `LOG_LEN` forwards words unchanged. A first-level setting with `s = 0`, `s > LOG_LEN` or `t >= s` turns off all four levels, and the output then equals the input.
- R6: The first result of a pass appears `4 + sum(2^t over active levels)` cycles after its first word is presented. The results come out in position order.
- R7: Four passes that each start where the previous one stopped (first pass at `s=1, t=0`) give a fully ascending sequence of `SEQ_LEN` words.
- R8: The words of a pass must arrive on consecutive cycles. Idle cycles between passes are allowed. A new pass may follow the previous one's last word directly, because each level counts positions modulo `SEQ_LEN`.
- R9: Every valid input word produces exactly one valid output word, and output data is never unknown while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input word, unsigned |
| cfg_stage | input | CFG_W | Stage number of the first level |
| cfg_step | input | CFG_W | Step number of the first level |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output word in position order |

## Verification
A result is due `4 + sum of active pairing distances` cycles after the word that starts it. With all levels off this is 4 cycles, and with the first level at `s=1, t=0` it is 12 cycles. The bench works out this number from the stage/step progression for every pass and compares it with the gap between the cycle counts of the first driven word and the first captured result. Inputs are driven and outputs captured on the falling clock edge, one half period away from the registers. Each pass is fully drained before the bench compares the whole captured block with its own model of the network steps.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int unsigned DATA_W   = 16;
    localparam int unsigned LOG_LEN  = 5;
    localparam int unsigned LEVELS   = 4;

    localparam int unsigned SEQ_LEN  = 1 << LOG_LEN;
    localparam int unsigned MAX_DIST = SEQ_LEN / 2;
    localparam int unsigned POS_W    = LOG_LEN;
    localparam int unsigned CFG_W    = $clog2(LOG_LEN + 2);
    localparam int unsigned TAP_W    = $clog2(MAX_DIST);

    typedef logic [DATA_W-1:0] word_t;

    // one stream beat; inside a delay line "valid" marks a finished result
    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

    typedef struct packed {
        logic             active;
        logic [CFG_W-1:0] stage;
        logic [CFG_W-1:0] step;
    } lvl_cfg_t;

    function automatic lvl_cfg_t first_cfg(logic [CFG_W-1:0] stage, logic [CFG_W-1:0] step);
        lvl_cfg_t c;
        c.stage  = stage;
        c.step   = step;
        c.active = (stage != '0) && (stage <= CFG_W'(LOG_LEN)) && (step < stage);
        return c;
    endfunction

    // walk one step further through the network
    function automatic lvl_cfg_t next_cfg(lvl_cfg_t c);
        lvl_cfg_t n;
        if (c.step == '0) begin
            n.stage = c.stage + 1'b1;
            n.step  = c.stage;
        end else begin
            n.stage = c.stage;
            n.step  = c.step - 1'b1;
        end
        n.active = c.active && (n.stage <= CFG_W'(LOG_LEN));
        return n;
    endfunction

    function automatic logic must_swap(word_t lower, word_t upper, logic desc);
        return desc ? (lower < upper) : (lower > upper);
    endfunction

endpackage

// File: rtl/bcs_commutator.sv
module bcs_commutator
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  beat_t            push,
    input  logic [TAP_W-1:0] tap_sel,
    output beat_t            tap
);

    beat_t line [MAX_DIST];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(MAX_DIST); k++) begin
                line[k] <= '0;
            end
        end else begin
            line[0] <= push;
            for (int k = 1; k < int'(MAX_DIST); k++) begin
                line[k] <= line[k-1];
            end
        end
    end

    assign tap = line[tap_sel];

endmodule

// File: rtl/bcs_level.sv
module bcs_level
    import bcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_cfg_t cfg,
    input  beat_t    din,
    output beat_t    dout
);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_by_step;
    logic [POS_W-1:0] pos_by_stage;
    logic [TAP_W-1:0] tap_sel;
    logic             upper_half;
    logic             desc;
    logic             swap;
    beat_t            tap;
    beat_t            push;
    beat_t            nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (din.valid) begin
            pos <= pos + 1'b1;
        end
    end

    always_comb begin
        pos_by_step  = pos >> cfg.step;
        pos_by_stage = pos >> cfg.stage;
        tap_sel      = cfg.active ? TAP_W'((1 << cfg.step) - 1) : '0;
        upper_half   = cfg.active && pos_by_step[0];
        desc         = (cfg.stage < CFG_W'(LOG_LEN)) && pos_by_stage[0];
        swap         = must_swap(tap.data, din.data, desc);

        if (!cfg.active) begin
            nxt  = din;
            push = '0;
        end else if (din.valid && upper_half) begin
            nxt.valid  = 1'b1;
            nxt.data   = swap ? din.data : tap.data;
            push.valid = 1'b1;
            push.data  = swap ? tap.data : din.data;
        end else begin
            nxt        = tap;
            push.valid = 1'b0;
            push.data  = din.valid ? din.data : '0;
        end
    end

    bcs_commutator u_comm (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .tap_sel (tap_sel),
        .tap     (tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout <= nxt;
        end
    end

endmodule

// File: rtl/bitonic_cascade.sv
module bitonic_cascade
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CFG_W-1:0]  cfg_stage,
    input  logic [CFG_W-1:0]  cfg_step,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    lvl_cfg_t cfg_chain [LEVELS];
    beat_t    link      [LEVELS+1];

    assign cfg_chain[0]  = first_cfg(cfg_stage, cfg_step);
    assign link[0].valid = in_valid;
    assign link[0].data  = in_data;

    for (genvar g = 0; g < int'(LEVELS); g++) begin : g_lvl
        if (g + 1 < int'(LEVELS)) begin : g_adv
            assign cfg_chain[g+1] = next_cfg(cfg_chain[g]);
        end

        bcs_level u_lvl (
            .clk  (clk),
            .rst  (rst),
            .cfg  (cfg_chain[g]),
            .din  (link[g]),
            .dout (link[g+1])
        );
    end

    assign out_valid = link[LEVELS].valid;
    assign out_data  = link[LEVELS].data;

endmodule

// File: rtl/bitonic_cascade_chk.sv
module bitonic_cascade_chk
    import bcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CFG_W-1:0]  cfg_stage,
    input logic [CFG_W-1:0]  cfg_step,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    localparam int unsigned CAP = LEVELS * MAX_DIST + LEVELS;

    logic       was_rst;
    logic [7:0] inflight;
    logic [2:0] byp_run;
    lvl_cfg_t   head;

    assign head = first_cfg(cfg_stage, cfg_step);

    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (rst) begin
            inflight <= '0;
            byp_run  <= '0;
        end else begin
            inflight <= inflight + {7'd0, in_valid} - {7'd0, out_valid};
            if (head.active) begin
                byp_run <= '0;
            end else if (byp_run != 3'd5) begin
                byp_run <= byp_run + 1'b1;
            end
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        was_rst |-> !out_valid);

    p_no_phantom_output_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    p_known_output_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));

    p_bounded_inflight_r6: assert property (@(posedge clk) disable iff (rst)
        inflight <= 8'(CAP));

    p_bypass_passthrough_r5: assert property (@(posedge clk) disable iff (rst)
        (byp_run == 3'd5) |-> (out_valid == $past(in_valid, 4)) &&
                               (!out_valid || out_data == $past(in_data, 4)));

endmodule

bind bitonic_cascade bitonic_cascade_chk u_chk (.*);

// File: tb/bitonic_cascade_tb.sv
module bitonic_cascade_tb;
    import bcs_pkg::*;

    localparam int N = int'(SEQ_LEN);
    localparam int L = int'(LOG_LEN);
    // {stage[3:0], step[3:0], pattern[3:0]}; pattern 15 = all equal, 14 = extremes
    localparam int NT = 12;
    localparam logic [11:0] TBL [NT] = '{
        12'h101, 12'h212, 12'h203, 12'h324, 12'h305, 12'h436,
        12'h547, 12'h528, 12'h50F, 12'h41E, 12'h009, 12'h22A
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [CFG_W-1:0]  cfg_stage = '0;
    logic [CFG_W-1:0]  cfg_step = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    int    cyc = 0;
    int    ncap = 0;
    int    first_out = -1;
    int    first_in = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    word_t stim [64];
    word_t mdl  [64];
    word_t cap  [64];

    bitonic_cascade u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cfg_stage(cfg_stage), .cfg_step(cfg_step),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ncap == 0) first_out = cyc;
            if (ncap < 64) cap[ncap] = out_data;
            ncap = ncap + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic word_t gen(int pat, int i);
        if (pat == 15) return word_t'(16'h5A5A);
        if (pat == 14) return (i % 3 == 0) ? '1 : '0;
        return word_t'((pat * 7919 + i * 40503 + i * i * 13) ^ (pat << 9));
    endfunction

    function automatic bit in_range(int s, int t);
        return (s >= 1) && (s <= L) && (t < s);
    endfunction

    task automatic model_step(int base, int s, int t);
        int d = 1 << t;
        for (int i = 0; i < N; i++) begin
            if ((i & d) == 0) begin
                bit    desc = (s < L) && (((i >> s) & 1) == 1);
                word_t a = mdl[base + i];
                word_t b = mdl[base + i + d];
                if (desc ? (a < b) : (a > b)) begin
                    mdl[base + i]     = b;
                    mdl[base + i + d] = a;
                end
            end
        end
    endtask

    // applies the four steps of one pass; returns the expected latency
    task automatic model_pass(int base, int s0, int t0, output int lat);
        int s = s0;
        int t = t0;
        bit act = in_range(s0, t0);
        lat = 4;
        for (int k = 0; k < 4; k++) begin
            if (act) begin
                model_step(base, s, t);
                lat += (1 << t);
            end
            if (t == 0) begin
                t = s;
                s = s + 1;
            end else begin
                t = t - 1;
            end
            act = act && (s <= L);
        end
    endtask

    task automatic run_pass(int s, int t, int nblk);
        ncap = 0;
        first_out = -1;
        cfg_stage = CFG_W'(s);
        cfg_step  = CFG_W'(t);
        for (int i = 0; i < nblk * N; i++) begin
            @(negedge clk);
            if (i == 0) first_in = cyc;
            in_valid = 1'b1;
            in_data  = stim[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 0; w < 200 && ncap < nblk * N; w++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic compare_block(int cnt, string req);
        int bad = 0;
        int at = -1;
        for (int i = 0; i < cnt; i++) begin
            if (cap[i] !== mdl[i]) begin
                bad++;
                if (at < 0) at = i;
            end
        end
        if (at < 0) at = 0;
        check(bad == 0, req, $sformatf("data at position %0d", at),
              int'(cap[at]), int'(mdl[at]));
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs quiet right after reset
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);

        // table walk: R2/R3/R4 data, R5 bypass, R6 latency, R9 count
        for (int e = 0; e < NT; e++) begin
            int s   = int'(TBL[e][11:8]);
            int t   = int'(TBL[e][7:4]);
            int pat = int'(TBL[e][3:0]);
            string tag = in_range(s, t) ? "R2/R3/R4" : "R5";
            for (int i = 0; i < N; i++) begin
                stim[i] = gen(pat, i);
                mdl[i]  = stim[i];
            end
            model_pass(0, s, t, lat);
            run_pass(s, t, 1);
            check(ncap == N, "R9", $sformatf("word count entry %0d", e), ncap, N);
            compare_block(N, tag);
            check(first_out - first_in == lat, "R6",
                  $sformatf("latency entry %0d", e), first_out - first_in, lat);
        end

        // R8: two passes back to back without idle cycles
        for (int i = 0; i < 2 * N; i++) begin
            stim[i] = gen(3 + i / N, i);
            mdl[i]  = stim[i];
        end
        model_pass(0, 2, 1, lat);
        model_pass(N, 2, 1, lat);
        run_pass(2, 1, 2);
        check(ncap == 2 * N, "R8", "back-to-back word count", ncap, 2 * N);
        compare_block(2 * N, "R8");

        // R7: full sort in four chained passes
        begin
            int s = 1;
            int t = 0;
            for (int i = 0; i < N; i++) stim[i] = gen(11, i);
            for (int p = 0; p < 4; p++) begin
                for (int i = 0; i < N; i++) mdl[i] = stim[i];
                model_pass(0, s, t, lat);
                run_pass(s, t, 1);
                check(ncap == N, "R7", $sformatf("pass %0d count", p), ncap, N);
                compare_block(N, "R7");
                for (int i = 0; i < N; i++) stim[i] = cap[i];
                for (int k = 0; k < 4; k++) begin
                    if (t == 0) begin
                        t = s;
                        s = s + 1;
                    end else begin
                        t = t - 1;
                    end
                end
            end
            begin
                int unsorted = 0;
                for (int i = 1; i < N; i++) if (cap[i-1] > cap[i]) unsorted++;
                check(unsorted == 0, "R7", "descents after four passes", unsorted, 0);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule